// File: doc/BRIEF.md
# Register-Mapped Reload Timer with Timestamp

This block is a small system timer that software reaches over a word-addressed register bus with separate read and write strobes. It holds a 32-bit timestamp that advances once per tick enable and can be overwritten, and one countdown timer. The countdown runs either periodically or as a one-shot, and both settings live in a single reload/control word.

When the countdown expires it sets a pending flag in a status word. Software clears that flag by writing a 1 to it. A level interrupt follows the pending flag unless an external mask input blocks it. Counters move only on cycles where `tick_en` is high, so one clock can drive timers of any tick rate.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset the timestamp, the control word, the current count and the status word are all zero, `irq` is low and `bus_rdata` is zero.
- R2: The timestamp at word address 0 adds one on every cycle with `tick_en` high and wraps from all ones to zero. A write to word 0 loads `bus_wdata`, and on that cycle the write wins over the tick.
- R3: The control word at word address 2 reads back as written. Bit 0 enables the timer, bit 1 selects one-shot (set) or periodic (clear), and bits 31:2 are the reload field. A write with bit 0 set loads the count with `bus_wdata` whose two low bits are forced to zero. No tick is applied on the cycle of a control write.
- R4: While enabled, each tick lowers the count at word address 1 by one. A tick that finds the count at 1 or 0 is an expiry and sets the pending flag.
- R5: In periodic mode an expiry loads the count from the reload field with the two low bits zero, so the timer keeps running.
- R6: In one-shot mode an expiry sets the count to zero and clears control bit 0, while bits 31:1 keep their values.
- R7: Status word address 8 shows the pending flag in bit 0, and bits 31:1 read as zero. Writing 1 to bit 0 clears the flag and writing 0 to it has no effect. An expiry in the same cycle as a clear leaves the flag set.
- R8: `irq` is high exactly when the pending flag is set and `irq_mask` is low.
- R9: While control bit 0 is clear the count does not change. Writing 0 to the control word stops the timer.
- R10: Writes to word address 1 and to unmapped addresses change nothing. Reads of unmapped addresses return zero.
- R11: `bus_rdata` takes the addressed value as it was before the clock edge where `bus_rd` is sampled high, and it holds that value on cycles without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Tick enable that advances both counters |
| bus_addr | input | 4 | Word address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_mask | input | 1 | When high, blocks the interrupt |
| irq | output | 1 | Level interrupt for a pending expiry |

## Verification
The assertions assume that `tick_en`, the strobes and `irq_mask` are stable and known around each rising edge. They also assume that a write strobe is held for exactly one cycle for each intended register update. The stimulus drives every input on the falling edge and holds it for a single whole cycle, so both assumptions hold. Random writes pick only the mapped words and one unmapped word. Random reload values are kept small, so expiries in both modes happen often within the run.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int unsigned DW        = 32;
    localparam int unsigned MODE_BITS = 2;
    localparam int unsigned EN_BIT    = 0;
    localparam int unsigned ONESHOT_BIT = 1;
    localparam int unsigned PEND_BIT  = 0;

    localparam int unsigned IDX_STAMP = 0;
    localparam int unsigned IDX_COUNT = 1;
    localparam int unsigned IDX_CTRL  = 2;
    localparam int unsigned IDX_STAT  = 8;

    typedef logic [DW-1:0] word_t;

    typedef struct packed {
        logic  wr_stamp;
        logic  wr_ctrl;
        logic  wr_stat;
        word_t wdata;
    } wr_req_t;

    typedef struct packed {
        word_t ctrl;
        word_t count;
        logic  pend;
    } cd_state_t;
endpackage

// File: rtl/tmr_stamp.sv
module tmr_stamp
    import tmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick_en,
    input  logic  wr_stamp,
    input  word_t wdata,
    output word_t stamp
);
    word_t stamp_d, stamp_q;

    always_comb begin
        stamp_d = stamp_q;
        if (wr_stamp) begin
            stamp_d = wdata;
        end else if (tick_en) begin
            stamp_d = stamp_q + word_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stamp_q <= '0;
        end else begin
            stamp_q <= stamp_d;
        end
    end

    assign stamp = stamp_q;
endmodule

// File: rtl/tmr_countdown.sv
module tmr_countdown
    import tmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick_en,
    input  logic  wr_ctrl,
    input  logic  wr_stat,
    input  word_t wdata,
    output word_t ctrl,
    output word_t count,
    output logic  pend
);
    cd_state_t st_d, st_q;
    word_t     reload_val;
    logic      expire;
    logic      clear_req;

    always_comb begin
        reload_val = {st_q.ctrl[DW-1:MODE_BITS], {MODE_BITS{1'b0}}};
        expire     = 1'b0;
        clear_req  = wr_stat && wdata[PEND_BIT];
        st_d       = st_q;

        if (wr_ctrl) begin
            st_d.ctrl = wdata;
            if (wdata[EN_BIT]) begin
                st_d.count = {wdata[DW-1:MODE_BITS], {MODE_BITS{1'b0}}};
            end
        end else if (st_q.ctrl[EN_BIT] && tick_en) begin
            if (st_q.count <= word_t'(1)) begin
                expire = 1'b1;
                if (st_q.ctrl[ONESHOT_BIT]) begin
                    st_d.count        = '0;
                    st_d.ctrl[EN_BIT] = 1'b0;
                end else begin
                    st_d.count = reload_val;
                end
            end else begin
                st_d.count = st_q.count - word_t'(1);
            end
        end

        st_d.pend = expire || (st_q.pend && !clear_req);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl  = st_q.ctrl;
    assign count = st_q.count;
    assign pend  = st_q.pend;
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
    import tmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  word_t             wdata,
    input  word_t             stamp,
    input  word_t             count,
    input  word_t             ctrl,
    input  logic              pend,
    output wr_req_t           req,
    output word_t             rdata
);
    localparam logic [ADDR_W-1:0] A_STAMP = IDX_STAMP[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_COUNT = IDX_COUNT[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_CTRL  = IDX_CTRL[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_STAT  = IDX_STAT[ADDR_W-1:0];

    word_t rdata_d, rdata_q;
    word_t sel_val;

    always_comb begin
        req.wr_stamp = wr && (addr == A_STAMP);
        req.wr_ctrl  = wr && (addr == A_CTRL);
        req.wr_stat  = wr && (addr == A_STAT);
        req.wdata    = wdata;

        case (addr)
            A_STAMP: sel_val = stamp;
            A_COUNT: sel_val = count;
            A_CTRL:  sel_val = ctrl;
            A_STAT:  sel_val = word_t'(pend);
            default: sel_val = '0;
        endcase

        rdata_d = rd ? sel_val : rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
    import tmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              irq_mask,
    output logic              irq
);
    wr_req_t req;
    word_t   stamp;
    word_t   cur_count;
    word_t   ctrl_word;
    logic    pend;

    tmr_regif #(.ADDR_W(ADDR_W)) u_regif (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .wr    (bus_wr),
        .rd    (bus_rd),
        .wdata (bus_wdata),
        .stamp (stamp),
        .count (cur_count),
        .ctrl  (ctrl_word),
        .pend  (pend),
        .req   (req),
        .rdata (bus_rdata)
    );

    tmr_stamp u_stamp (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .wr_stamp (req.wr_stamp),
        .wdata    (req.wdata),
        .stamp    (stamp)
    );

    tmr_countdown u_cd (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .wr_ctrl (req.wr_ctrl),
        .wr_stat (req.wr_stat),
        .wdata   (req.wdata),
        .ctrl    (ctrl_word),
        .count   (cur_count),
        .pend    (pend)
    );

    assign irq = pend && !irq_mask;
endmodule

// File: rtl/tmr_checks.sv
module tmr_checks
    import tmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DW-1:0]     bus_wdata,
    input logic              irq_mask,
    input logic              irq,
    input logic [DW-1:0]     stamp,
    input logic [DW-1:0]     cur_count,
    input logic [DW-1:0]     ctrl_word,
    input logic              pend
);
    localparam logic [ADDR_W-1:0] A_STAMP = IDX_STAMP[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_CTRL  = IDX_CTRL[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_STAT  = IDX_STAT[ADDR_W-1:0];

    logic seen_q;
    logic wr_stamp, wr_ctrl, clr_stat, run_tick, at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    assign wr_stamp = bus_wr && (bus_addr == A_STAMP);
    assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    assign clr_stat = bus_wr && (bus_addr == A_STAT) && bus_wdata[PEND_BIT];
    assign run_tick = tick_en && ctrl_word[EN_BIT] && !wr_ctrl;
    assign at_end   = cur_count <= word_t'(1);

    assert_stamp_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(tick_en) && !$past(wr_stamp)) |-> stamp == $past(stamp) + word_t'(1));

    assert_stamp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(tick_en) && !$past(wr_stamp)) |-> $stable(stamp));

    assert_expiry_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_tick && at_end) |=> pend);

    assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_tick && at_end && ctrl_word[ONESHOT_BIT]) |=> (!ctrl_word[EN_BIT] && cur_count == '0));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_word[EN_BIT] && !wr_ctrl) |=> $stable(cur_count));

    assert_pend_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $fell(pend)) |-> $past(clr_stat));

    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> !irq);
endmodule

bind sys_tick_timer tmr_checks #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .irq_mask  (irq_mask),
    .irq       (irq),
    .stamp     (stamp),
    .cur_count (cur_count),
    .ctrl_word (ctrl_word),
    .pend      (pend)
);

// File: tb/sys_tick_timer_test.sv
module sys_tick_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_mask = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_ts = '0, m_ctrl = '0, m_cnt = '0, m_rdata = '0;
    logic        m_pend = 1'b0;

    sys_tick_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_mask(irq_mask), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [3:0] a);
        case (a)
            4'd0:    return m_ts;
            4'd1:    return m_cnt;
            4'd2:    return m_ctrl;
            4'd8:    return {31'd0, m_pend};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            4'd0:    return "R2";
            4'd1:    return "R4";
            4'd2:    return "R3";
            4'd8:    return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic model_step(input bit tk, input bit wr, input bit rd,
                              input logic [3:0] a, input logic [31:0] wd);
        logic [31:0] n_ts, n_ctrl, n_cnt;
        bit set_p, clr_p;
        n_ts = m_ts; n_ctrl = m_ctrl; n_cnt = m_cnt; set_p = 0;
        clr_p = wr && a == 4'd8 && wd[0];
        if (rd) m_rdata = model_read(a);
        if (wr && a == 4'd0) n_ts = wd;
        else if (tk) n_ts = m_ts + 32'd1;
        if (wr && a == 4'd2) begin
            n_ctrl = wd;
            if (wd[0]) n_cnt = {wd[31:2], 2'b00};
        end else if (m_ctrl[0] && tk) begin
            if (m_cnt <= 32'd1) begin
                set_p = 1;
                if (m_ctrl[1]) begin n_cnt = 0; n_ctrl[0] = 1'b0; end
                else n_cnt = {m_ctrl[31:2], 2'b00};
            end else n_cnt = m_cnt - 32'd1;
        end
        m_pend = set_p || (m_pend && !clr_p);
        m_ts = n_ts; m_ctrl = n_ctrl; m_cnt = n_cnt;
    endtask

    // one cycle: drive at falling edge, check at the next falling edge
    task automatic cyc(input bit tk, input bit wr, input bit rd,
                       input logic [3:0] a, input logic [31:0] wd, input string tag);
        string t;
        tick_en = tk; bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        model_step(tk, wr, rd, a, wd);
        @(negedge clk);
        tick_en = 0; bus_wr = 0; bus_rd = 0;
        t = (tag != "") ? tag : tag_of(a);
        if (rd || tag != "")
            check(bus_rdata === m_rdata, t, "read data", bus_rdata, m_rdata);
        check(irq === (m_pend && !irq_mask), "R8", "irq level", {31'd0, irq},
              {31'd0, m_pend && !irq_mask});
    endtask

    task automatic rd_reg(input logic [3:0] a, input string tag);
        cyc(1'b0, 1'b0, 1'b1, a, 32'd0, tag);
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] wd, input bit tk);
        cyc(tk, 1'b1, 1'b0, a, wd, "");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] addrs [5] = '{4'd0, 4'd1, 4'd2, 4'd8, 4'd5};
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(irq === 1'b0, "R1", "irq in reset", {31'd0, irq}, 32'd0);
        check(bus_rdata === 32'd0, "R1", "rdata in reset", bus_rdata, 32'd0);
        rst_n = 1'b1;
        rd_reg(4'd0, "R1"); rd_reg(4'd1, "R1"); rd_reg(4'd2, "R1"); rd_reg(4'd8, "R1");

        // R2: write beats tick, then wrap
        wr_reg(4'd0, 32'hFFFF_FFFE, 1'b1);
        rd_reg(4'd0, "R2");
        cyc(1'b1, 0, 0, 4'd0, 0, "");
        cyc(1'b1, 0, 0, 4'd0, 0, "");
        rd_reg(4'd0, "R2");

        // R5: periodic with reload 8
        wr_reg(4'd2, 32'h0000_0009, 1'b0);
        rd_reg(4'd1, "R3");
        for (int i = 0; i < 20; i++) cyc(1'b1, 0, 1, 4'd1, 0, "R5");

        // R7: write 0 keeps, write 1 clears
        wr_reg(4'd8, 32'hFFFF_FFFE, 1'b0);
        rd_reg(4'd8, "R7");
        wr_reg(4'd2, 32'h0, 1'b0);
        wr_reg(4'd8, 32'h1, 1'b0);
        rd_reg(4'd8, "R7");

        // R6: one-shot with reload 16, masked interrupt
        irq_mask = 1'b1;
        wr_reg(4'd2, 32'h0000_0013, 1'b0);
        for (int i = 0; i < 20; i++) cyc(1'b1, 0, 1, 4'd2, 0, "R6");
        rd_reg(4'd1, "R6");
        irq_mask = 1'b0;
        rd_reg(4'd8, "R8");

        // R7: expiry and clear in the same cycle
        wr_reg(4'd2, 32'h0000_0005, 1'b0);
        repeat (3) cyc(1'b1, 0, 0, 4'd0, 0, "");
        cyc(1'b1, 1, 0, 4'd8, 32'h1, "");
        rd_reg(4'd8, "R7");

        // R9: disable freezes the count
        wr_reg(4'd2, 32'h0000_0041, 1'b0);
        cyc(1'b1, 0, 0, 4'd0, 0, "");
        wr_reg(4'd2, 32'h0, 1'b0);
        repeat (5) cyc(1'b1, 0, 0, 4'd0, 0, "");
        rd_reg(4'd1, "R9");

        // R10: count and unmapped words ignore writes
        wr_reg(4'd1, 32'h1234_5678, 1'b0);
        wr_reg(4'd5, 32'hDEAD_BEEF, 1'b0);
        rd_reg(4'd1, "R10");
        rd_reg(4'd5, "R10");

        // R11: read data holds without a read strobe
        rd_reg(4'd0, "R11");
        cyc(1'b1, 0, 0, 4'd0, 0, "R11");
        cyc(1'b1, 0, 0, 4'd2, 0, "R11");

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [3:0]  a;
            logic [31:0] wd;
            bit wr, rd, tk;
            a  = addrs[$urandom_range(0, 4)];
            tk = ($urandom_range(0, 3) != 0);
            wr = ($urandom_range(0, 15) == 0);
            rd = ($urandom_range(0, 2) == 0);
            wd = $urandom();
            if (a == 4'd2) wd = {24'd0, wd[7:2], wd[1:0] | 2'b01};
            irq_mask = ($urandom_range(0, 7) == 0);
            cyc(tk, wr, rd, a, wd, "");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule